// File: doc/BRIEF.md
# Missing Load Tracker

The tracker sits beside the retirement stage of an out-of-order core. It learns which static loads cause most data-cache misses, so that helper-thread prefetch slices can be built for them. Each retiring instruction is presented once, with a flag that marks it as a load, the load's PC and a hit or miss flag. A load that misses and has no entry claims the lowest-numbered free entry. Once a load owns an entry, its executions and misses are counted there.

Every retired instruction, load or not, advances a window counter. When the window closes, every entry is judged in the same cycle. An entry is delinquent when its misses reach a programmable minimum and its miss ratio is above a programmable fraction. Delinquent entries survive into the next window, and those not already reported are offered one at a time on a valid/ready stream. All other entries are freed, and all counters start again from zero. A combinational query port lets any entry's state be read.

The reporting side is a two-state machine. In `RPT_IDLE` it waits until an entry is pending. It then takes the lowest-numbered pending entry and enters `RPT_SHOW`. In `RPT_SHOW` the PC is held on the stream until it is accepted. After an acceptance the machine either takes the next pending entry in the same cycle and stays in `RPT_SHOW`, or returns to `RPT_IDLE` when none is left.

Top module: `miss_load_tracker`

## Requirements
- R1: After reset all entries are invalid with zero counts and no flag, and `dl_valid` is low.
- R2: A retiring load that misses and matches no valid entry takes the lowest-numbered free entry, which then holds its PC with executions 1 and misses 1.
- R3: A load that hits and matches no entry allocates nothing, and a missing load that finds the table full is not tracked.
- R4: A load whose PC matches a valid entry adds one execution to it, plus one miss when it missed. A second entry is never created for the same PC, and an entry's misses never exceed its executions.
- R5: Judgement happens in the cycle in which the WINDOW-th retired instruction since the last judgement retires. That instruction's own update or allocation is included in the judgement.
- R6: An entry is delinquent when misses >= `cfg_min_miss` and misses*16 > executions*`cfg_ratio`, so the ratio is in sixteenths. Equality on the ratio is not delinquent.
- R7: At judgement, non-delinquent entries are freed. Delinquent entries keep their PC and stay flagged, and every execution and miss count returns to zero.
- R8: An entry that becomes delinquent while not flagged is offered exactly once on `dl_pc`. A PC that is still flagged is not offered again. `dl_valid` and `dl_pc` hold steady until `dl_ready` is seen.
- R9: Execution and miss counts saturate at 2^CNT_W-1 instead of wrapping.
- R10: A retirement that is not a load only advances the window, and a cycle with `ret_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_is_load | input | 1 | The retiring instruction is a load |
| ret_pc | input | PC_W | PC of the retiring load |
| ret_miss | input | 1 | The load missed in the data cache |
| cfg_min_miss | input | CNT_W | Minimum miss count for delinquency |
| cfg_ratio | input | FRAC_W | Miss-ratio threshold in sixteenths |
| dl_valid | output | 1 | A delinquent PC is offered |
| dl_ready | input | 1 | Consumer accepts the offered PC |
| dl_pc | output | PC_W | Offered delinquent PC |
| q_idx | input | IDX_W | Entry selected for query |
| q_valid | output | 1 | Selected entry is valid |
| q_pc | output | PC_W | Selected entry's PC |
| q_execs | output | CNT_W | Selected entry's execution count |
| q_misses | output | CNT_W | Selected entry's miss count |
| q_flagged | output | 1 | Selected entry is flagged delinquent |

## Verification
Two things can land in the same cycle. The retirement that closes the window may be a missing load that allocates a new entry, and the consumer may accept a report in the cycle that judgement marks new entries pending. A directed window ends on a missing load of an untracked PC with a minimum of one miss, and that entry must be allocated, flagged and reported in one step. Random traffic with a ready rate below one makes acceptances coincide with judgement edges. A bench model of the table, with counts, flags and pending bits, judges both cases: each accepted PC must match a pending model entry, and the pending set must be empty after draining.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
    typedef enum logic [0:0] {
        RPT_IDLE,
        RPT_SHOW
    } rpt_state_e;
endpackage

// File: rtl/mlt_window.sv
module mlt_window #(
    parameter int WINDOW = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic close
);
    localparam int W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [W-1:0] cnt_q;

    assign close = tick && (cnt_q == W'(WINDOW - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (close) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mlt_table.sv
module mlt_table #(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 32,
    parameter int CNT_W   = 16,
    parameter int FRAC_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PROD_W = CNT_W + FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_valid,
    input  logic [PC_W-1:0]          ld_pc,
    input  logic                     ld_miss,
    input  logic                     judge,
    input  logic [CNT_W-1:0]         cfg_min,
    input  logic [FRAC_W-1:0]        cfg_ratio,
    input  logic                     ack,
    input  logic [IDX_W-1:0]         ack_idx,
    output logic [ENTRIES-1:0]       valid_o,
    output logic [ENTRIES-1:0]       flag_o,
    output logic [ENTRIES-1:0]       pend_nxt_o,
    output logic [ENTRIES*PC_W-1:0]  pc_flat_o,
    output logic [ENTRIES*PC_W-1:0]  pc_nxt_flat_o,
    output logic [ENTRIES*CNT_W-1:0] exec_flat_o,
    output logic [ENTRIES*CNT_W-1:0] miss_flat_o
);
    logic [ENTRIES-1:0] valid_q, valid_d, flag_q, flag_d, pend_q, pend_d;
    logic [ENTRIES-1:0] hit_vec, hot;
    logic [PC_W-1:0]    pc_q   [ENTRIES];
    logic [PC_W-1:0]    pc_d   [ENTRIES];
    logic [CNT_W-1:0]   exec_q [ENTRIES];
    logic [CNT_W-1:0]   exec_d [ENTRIES];
    logic [CNT_W-1:0]   miss_q [ENTRIES];
    logic [CNT_W-1:0]   miss_d [ENTRIES];
    logic [PROD_W-1:0]  lhs    [ENTRIES];
    logic [PROD_W-1:0]  rhs    [ENTRIES];
    logic [IDX_W-1:0]   alloc_idx;
    logic               alloc_found, alloc_en;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
        return (x == '1) ? x : x + 1'b1;
    endfunction

    // Match lookup and lowest free slot.
    always_comb begin
        hit_vec     = '0;
        alloc_idx   = '0;
        alloc_found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_vec[i] = valid_q[i] && (pc_q[i] == ld_pc);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                alloc_found = 1'b1;
                alloc_idx   = IDX_W'(i);
            end
        end
    end

    assign alloc_en = ld_valid && ld_miss && !(|hit_vec) && alloc_found;

    // Per-entry update, then judgement on the updated values.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_d[i] = valid_q[i];
            flag_d[i]  = flag_q[i];
            pend_d[i]  = pend_q[i];
            pc_d[i]    = pc_q[i];
            exec_d[i]  = exec_q[i];
            miss_d[i]  = miss_q[i];
            if (ld_valid && hit_vec[i]) begin
                exec_d[i] = sat_inc(exec_q[i]);
                if (ld_miss) begin
                    miss_d[i] = sat_inc(miss_q[i]);
                end
            end
            if (alloc_en && (alloc_idx == IDX_W'(i))) begin
                valid_d[i] = 1'b1;
                flag_d[i]  = 1'b0;
                pend_d[i]  = 1'b0;
                pc_d[i]    = ld_pc;
                exec_d[i]  = CNT_W'(1);
                miss_d[i]  = CNT_W'(1);
            end
            if (ack && (ack_idx == IDX_W'(i))) begin
                pend_d[i] = 1'b0;
            end
            lhs[i] = {miss_d[i], {FRAC_W{1'b0}}};
            rhs[i] = PROD_W'(exec_d[i]) * PROD_W'(cfg_ratio);
            hot[i] = valid_d[i] && (miss_d[i] >= cfg_min) && (lhs[i] > rhs[i]);
            if (judge) begin
                if (hot[i]) begin
                    if (!flag_d[i]) begin
                        flag_d[i] = 1'b1;
                        pend_d[i] = 1'b1;
                    end
                end else begin
                    valid_d[i] = 1'b0;
                    flag_d[i]  = 1'b0;
                    pend_d[i]  = 1'b0;
                end
                exec_d[i] = '0;
                miss_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            flag_q  <= '0;
            pend_q  <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                pc_q[i]   <= '0;
                exec_q[i] <= '0;
                miss_q[i] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            flag_q  <= flag_d;
            pend_q  <= pend_d;
            for (int i = 0; i < ENTRIES; i++) begin
                pc_q[i]   <= pc_d[i];
                exec_q[i] <= exec_d[i];
                miss_q[i] <= miss_d[i];
            end
        end
    end

    assign valid_o    = valid_q;
    assign flag_o     = flag_q;
    assign pend_nxt_o = pend_d;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign pc_flat_o[g*PC_W +: PC_W]     = pc_q[g];
        assign pc_nxt_flat_o[g*PC_W +: PC_W] = pc_d[g];
        assign exec_flat_o[g*CNT_W +: CNT_W] = exec_q[g];
        assign miss_flat_o[g*CNT_W +: CNT_W] = miss_q[g];
    end
endmodule

// File: rtl/mlt_reporter.sv
module mlt_reporter
    import mlt_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ENTRIES-1:0]      pend_nxt,
    input  logic [ENTRIES*PC_W-1:0] pc_nxt_flat,
    input  logic                    dl_ready,
    output logic                    dl_valid,
    output logic [PC_W-1:0]         dl_pc,
    output logic                    ack,
    output logic [IDX_W-1:0]        ack_idx
);
    rpt_state_e       state_q, state_d;
    logic [IDX_W-1:0] sel_q, pick_idx;
    logic [PC_W-1:0]  pc_q;
    logic             pick_any, load;

    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (pend_nxt[i]) begin
                pick_any = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            RPT_IDLE: begin
                if (pick_any) begin
                    state_d = RPT_SHOW;
                    load    = 1'b1;
                end
            end
            RPT_SHOW: begin
                if (dl_ready) begin
                    load    = pick_any;
                    state_d = pick_any ? RPT_SHOW : RPT_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RPT_IDLE;
            sel_q   <= '0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                sel_q <= pick_idx;
                pc_q  <= pc_nxt_flat[pick_idx*PC_W +: PC_W];
            end
        end
    end

    always_comb begin
        dl_valid = (state_q == RPT_SHOW);
        dl_pc    = pc_q;
        ack      = dl_valid && dl_ready;
        ack_idx  = sel_q;
    end
endmodule

// File: rtl/miss_load_tracker.sv
module miss_load_tracker #(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 32,
    parameter int CNT_W   = 16,
    parameter int FRAC_W  = 4,
    parameter int WINDOW  = 131072,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ret_is_load,
    input  logic [PC_W-1:0]   ret_pc,
    input  logic              ret_miss,
    input  logic [CNT_W-1:0]  cfg_min_miss,
    input  logic [FRAC_W-1:0] cfg_ratio,
    output logic              dl_valid,
    input  logic              dl_ready,
    output logic [PC_W-1:0]   dl_pc,
    input  logic [IDX_W-1:0]  q_idx,
    output logic              q_valid,
    output logic [PC_W-1:0]   q_pc,
    output logic [CNT_W-1:0]  q_execs,
    output logic [CNT_W-1:0]  q_misses,
    output logic              q_flagged
);
    logic                     win_close, ack;
    logic [IDX_W-1:0]         ack_idx;
    logic [ENTRIES-1:0]       ent_valid, ent_flag, pend_nxt;
    logic [ENTRIES*PC_W-1:0]  ent_pc_flat, pc_nxt_flat;
    logic [ENTRIES*CNT_W-1:0] ent_exec_flat, ent_miss_flat;

    mlt_window #(.WINDOW(WINDOW)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ret_valid),
        .close (win_close)
    );

    mlt_table #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W),
        .CNT_W   (CNT_W),
        .FRAC_W  (FRAC_W)
    ) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_valid      (ret_valid && ret_is_load),
        .ld_pc         (ret_pc),
        .ld_miss       (ret_miss),
        .judge         (win_close),
        .cfg_min       (cfg_min_miss),
        .cfg_ratio     (cfg_ratio),
        .ack           (ack),
        .ack_idx       (ack_idx),
        .valid_o       (ent_valid),
        .flag_o        (ent_flag),
        .pend_nxt_o    (pend_nxt),
        .pc_flat_o     (ent_pc_flat),
        .pc_nxt_flat_o (pc_nxt_flat),
        .exec_flat_o   (ent_exec_flat),
        .miss_flat_o   (ent_miss_flat)
    );

    mlt_reporter #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W)
    ) u_reporter (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_nxt    (pend_nxt),
        .pc_nxt_flat (pc_nxt_flat),
        .dl_ready    (dl_ready),
        .dl_valid    (dl_valid),
        .dl_pc       (dl_pc),
        .ack         (ack),
        .ack_idx     (ack_idx)
    );

    always_comb begin
        q_valid   = ent_valid[q_idx];
        q_flagged = ent_flag[q_idx];
        q_pc      = ent_pc_flat[q_idx*PC_W +: PC_W];
        q_execs   = ent_exec_flat[q_idx*CNT_W +: CNT_W];
        q_misses  = ent_miss_flat[q_idx*CNT_W +: CNT_W];
    end
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
    parameter int ENTRIES = 8,
    parameter int PC_W    = 32,
    parameter int CNT_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ret_valid,
    input logic                     ret_is_load,
    input logic [PC_W-1:0]          ret_pc,
    input logic                     judge,
    input logic                     dl_valid,
    input logic                     dl_ready,
    input logic [PC_W-1:0]          dl_pc,
    input logic [ENTRIES-1:0]       ent_valid,
    input logic [ENTRIES*PC_W-1:0]  ent_pc_flat,
    input logic [ENTRIES*CNT_W-1:0] ent_exec_flat,
    input logic [ENTRIES*CNT_W-1:0] ent_miss_flat
);
    logic [ENTRIES-1:0] match;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            match[i] = ent_valid[i] && (ent_pc_flat[i*PC_W +: PC_W] == ret_pc);
        end
    end

    // R8: an offer stays put until taken
    a_r8_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_valid && !dl_ready) |=> (dl_valid && $stable(dl_pc)));

    // R4: never two entries for one PC
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_is_load) |-> $onehot0(match));

    // R7: counts are zero right after judgement
    a_r7_clear_after_judge: assert property (@(posedge clk) disable iff (!rst_n)
        judge |=> ((ent_exec_flat == '0) && (ent_miss_flat == '0)));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // R9: a saturated count does not wrap
        a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            ((ent_exec_flat[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}) && !judge)
            |=> (ent_exec_flat[g*CNT_W +: CNT_W] == {CNT_W{1'b1}}));

        // R4: misses bounded by executions
        a_r4_miss_le_exec: assert property (@(posedge clk) disable iff (!rst_n)
            ent_miss_flat[g*CNT_W +: CNT_W] <= ent_exec_flat[g*CNT_W +: CNT_W]);
    end
endmodule

bind miss_load_tracker mlt_checker #(
    .ENTRIES (ENTRIES),
    .PC_W    (PC_W),
    .CNT_W   (CNT_W)
) u_mlt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ret_valid     (ret_valid),
    .ret_is_load   (ret_is_load),
    .ret_pc        (ret_pc),
    .judge         (win_close),
    .dl_valid      (dl_valid),
    .dl_ready      (dl_ready),
    .dl_pc         (dl_pc),
    .ent_valid     (ent_valid),
    .ent_pc_flat   (ent_pc_flat),
    .ent_exec_flat (ent_exec_flat),
    .ent_miss_flat (ent_miss_flat)
);

// File: tb/miss_load_tracker_bench.sv
`timescale 1ns/100ps
module miss_load_tracker_bench;
    localparam int N    = 8;
    localparam int PCW  = 32;
    localparam int CW   = 5;
    localparam int FW   = 4;
    localparam int WIN  = 48;
    localparam int MAXC = (1 << CW) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ret_valid = 1'b0, ret_is_load = 1'b0, ret_miss = 1'b0;
    logic [PCW-1:0] ret_pc = '0;
    logic [CW-1:0]  cfg_min_miss = CW'(3);
    logic [FW-1:0]  cfg_ratio = FW'(6);
    logic           dl_valid, dl_ready = 1'b0;
    logic [PCW-1:0] dl_pc;
    logic [2:0]     q_idx = '0;
    logic           q_valid, q_flagged;
    logic [PCW-1:0] q_pc;
    logic [CW-1:0]  q_execs, q_misses;

    miss_load_tracker #(
        .ENTRIES(N), .PC_W(PCW), .CNT_W(CW), .FRAC_W(FW), .WINDOW(WIN)
    ) u_miss_load_tracker (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_is_load(ret_is_load),
        .ret_pc(ret_pc), .ret_miss(ret_miss), .cfg_min_miss(cfg_min_miss),
        .cfg_ratio(cfg_ratio), .dl_valid(dl_valid), .dl_ready(dl_ready), .dl_pc(dl_pc),
        .q_idx(q_idx), .q_valid(q_valid), .q_pc(q_pc), .q_execs(q_execs),
        .q_misses(q_misses), .q_flagged(q_flagged)
    );

    always #2.5 clk = ~clk;

    // Reference model
    bit             m_v [N];
    bit             m_f [N];
    bit             m_p [N];
    logic [PCW-1:0] m_pc [N];
    int             m_e [N];
    int             m_m [N];
    int             m_win;
    int             checks = 0, fails = 0;
    bit             done = 0;

    function automatic logic [PCW-1:0] pool_pc(int k);
        return PCW'(32'h1000 + k * 4);
    endfunction

    function automatic bit is_hot(int e, int m);
        return (m >= int'(cfg_min_miss)) && (m * 16 > e * int'(cfg_ratio));
    endfunction

    function automatic int sat(int x);
        return (x >= MAXC) ? MAXC : x + 1;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_apply(bit v, bit ld, logic [PCW-1:0] pc, bit miss);
        int hit = -1;
        int fr = -1;
        bit last;
        if (!v) return;
        if (ld) begin
            for (int i = 0; i < N; i++) if (m_v[i] && m_pc[i] == pc) hit = i;
            if (hit >= 0) begin
                m_e[hit] = sat(m_e[hit]);
                if (miss) m_m[hit] = sat(m_m[hit]);
            end else if (miss) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) fr = i;
                if (fr >= 0) begin
                    m_v[fr] = 1; m_f[fr] = 0; m_p[fr] = 0;
                    m_pc[fr] = pc; m_e[fr] = 1; m_m[fr] = 1;
                end
            end
        end
        last = (m_win == WIN - 1);
        m_win = last ? 0 : m_win + 1;
        if (last) begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && is_hot(m_e[i], m_m[i])) begin
                    if (!m_f[i]) begin m_f[i] = 1; m_p[i] = 1; end
                end else begin
                    m_v[i] = 0; m_f[i] = 0; m_p[i] = 0;
                end
                m_e[i] = 0; m_m[i] = 0;
            end
        end
    endtask

    // One cycle: observe handshake, drive, update model, pass the edge.
    task automatic step(bit v, bit ld, logic [PCW-1:0] pc, bit miss, bit rdy);
        int j = -1;
        @(negedge clk);
        dl_ready = rdy;
        #0.1;
        if (dl_valid && dl_ready) begin
            for (int i = 0; i < N; i++) if (m_p[i] && m_pc[i] == dl_pc) j = i;
            chk(j >= 0, "R8", "accepted PC not pending", longint'(dl_pc), 0);
            if (j >= 0) m_p[j] = 0;
        end
        ret_valid = v; ret_is_load = ld; ret_pc = pc; ret_miss = miss;
        model_apply(v, ld, pc, miss);
        @(posedge clk);
        #0.1;
        ret_valid = 0; ret_is_load = 0; ret_miss = 0;
    endtask

    task automatic check_entry(int i, string req);
        longint act, exp;
        bit ok;
        q_idx = 3'(i);
        #0.1;
        if (m_v[i]) begin
            act = {q_valid, q_flagged, q_misses, q_execs, q_pc};
            exp = {1'b1, m_f[i], CW'(m_m[i]), CW'(m_e[i]), m_pc[i]};
            ok  = (act == exp);
        end else begin
            act = longint'(q_valid);
            exp = 0;
            ok  = !q_valid;
        end
        chk(ok, req, $sformatf("entry %0d", i), act, exp);
    endtask

    task automatic check_table(string req);
        for (int i = 0; i < N; i++) check_entry(i, req);
    endtask

    task automatic pad_to_last();
        while (m_win != WIN - 1) step(1, 0, '0, 0, 1);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_f[i] = 0; m_p[i] = 0; m_pc[i] = '0; m_e[i] = 0; m_m[i] = 0;
        end
        m_win = 0;
        repeat (4) @(posedge clk);
        #0.1;
        check_table("R1");
        chk(!dl_valid, "R1", "dl_valid", longint'(dl_valid), 0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        #0.1;

        // R3: hitting load with no entry is ignored
        step(1, 1, pool_pc(0), 0, 1);
        check_entry(0, "R3");
        chk(!q_valid, "R3", "hit allocated", longint'(q_valid), 0);
        // R2: first miss allocates entry 0
        step(1, 1, pool_pc(0), 1, 1);
        q_idx = 3'd0; #0.1;
        chk(q_valid && q_execs == 1 && q_misses == 1 && q_pc == pool_pc(0), "R2",
            "alloc", {q_valid, q_execs, q_misses}, {1'b1, 5'd1, 5'd1});
        // R4: updates, no duplicate
        step(1, 1, pool_pc(0), 1, 1);
        step(1, 1, pool_pc(0), 0, 1);
        q_idx = 3'd0; #0.1;
        chk(q_execs == 3 && q_misses == 2, "R4", "update", {q_execs, q_misses}, {5'd3, 5'd2});
        check_entry(1, "R4");
        // R10: non-load and idle cycles
        step(1, 0, pool_pc(0), 1, 1);
        step(0, 1, pool_pc(1), 1, 1);
        check_entry(0, "R10");
        check_entry(1, "R10");
        // R3: fill the table, then one more miss is dropped
        for (int k = 1; k < N; k++) step(1, 1, pool_pc(k), 1, 1);
        step(1, 1, pool_pc(N), 1, 1);
        check_table("R3");
        for (int i = 0; i < N; i++) begin
            q_idx = 3'(i); #0.1;
            chk(q_pc != pool_pc(N), "R3", "untracked PC present", longint'(q_pc), 0);
        end
        // R9: saturation
        for (int k = 0; k < 30; k++) step(1, 1, pool_pc(0), 1, 1);
        q_idx = 3'd0; #0.1;
        chk(q_execs == MAXC && q_misses == MAXC, "R9", "saturate",
            {q_execs, q_misses}, {5'd31, 5'd31});
        // R5: no judgement before the window closes
        pad_to_last();
        check_entry(0, "R5");
        step(1, 0, '0, 0, 1);
        check_table("R7");
        q_idx = 3'd0; #0.1;
        chk(q_valid && q_flagged && q_execs == 0, "R7", "survivor",
            {q_valid, q_flagged, q_execs}, {1'b1, 1'b1, 5'd0});
        q_idx = 3'd1; #0.1;
        chk(!q_valid, "R7", "freed", longint'(q_valid), 0);
        repeat (4) step(0, 0, '0, 0, 1);
        for (int i = 0; i < N; i++) chk(!m_p[i], "R8", "report drained", longint'(m_p[i]), 0);

        // R6: ratio boundary, minimum 2, ratio 8/16
        cfg_min_miss = CW'(2); cfg_ratio = FW'(8);
        step(1, 1, pool_pc(20), 1, 1); step(1, 1, pool_pc(20), 1, 1);
        step(1, 1, pool_pc(20), 0, 1); step(1, 1, pool_pc(20), 0, 1);
        step(1, 1, pool_pc(21), 1, 1); step(1, 1, pool_pc(21), 1, 1);
        step(1, 1, pool_pc(21), 0, 1);
        step(1, 1, pool_pc(22), 1, 1);
        pad_to_last();
        step(1, 0, '0, 0, 1);
        check_table("R6");
        q_idx = 3'd2; #0.1;
        chk(q_valid && q_flagged && q_pc == pool_pc(21), "R6", "above ratio",
            {q_valid, q_flagged}, {1'b1, 1'b1});
        q_idx = 3'd1; #0.1;
        chk(!q_valid, "R6", "ratio equal", longint'(q_valid), 0);
        q_idx = 3'd3; #0.1;
        chk(!q_valid, "R6", "below minimum", longint'(q_valid), 0);
        q_idx = 3'd0; #0.1;
        chk(!q_valid, "R7", "old survivor freed", longint'(q_valid), 0);

        // R5: allocation and judgement in one cycle
        cfg_min_miss = CW'(1); cfg_ratio = FW'(6);
        pad_to_last();
        step(1, 1, pool_pc(30), 1, 1);
        check_table("R5");
        q_idx = 3'd0; #0.1;
        chk(q_valid && q_flagged && q_pc == pool_pc(30), "R5", "same-cycle alloc",
            {q_valid, q_flagged}, {1'b1, 1'b1});
        for (int k = 0; k < 3; k++) begin
            step(0, 0, '0, 0, 0);
            chk(dl_valid && dl_pc == pool_pc(30), "R8", "hold",
                {dl_valid, dl_pc}, {1'b1, pool_pc(30)});
        end
        step(0, 0, '0, 0, 1);
        step(0, 0, '0, 0, 1);
        chk(!dl_valid, "R8", "single offer", longint'(dl_valid), 0);

        // R8: a flagged PC is not reported twice
        for (int k = 0; k < 3; k++) step(1, 1, pool_pc(30), 1, 1);
        pad_to_last();
        step(1, 0, '0, 0, 1);
        check_entry(0, "R8");
        for (int k = 0; k < 4; k++) begin
            step(0, 0, '0, 0, 1);
            chk(!dl_valid, "R8", "re-report", longint'(dl_valid), 0);
        end

        // Random traffic
        cfg_min_miss = CW'(3); cfg_ratio = FW'(6);
        for (int n = 0; n < 3000; n++) begin
            int k;
            bit v, ld, ms, rd;
            k  = int'($urandom % 12);
            v  = ($urandom % 100) < 85;
            ld = ($urandom % 2) == 1;
            ms = ($urandom % 100) < k * 8;
            rd = ($urandom % 100) < 75;
            step(v, ld, pool_pc(k), ms, rd);
            check_entry(int'($urandom % N), "R4");
        end
        repeat (20) step(0, 0, '0, 0, 1);
        for (int i = 0; i < N; i++) chk(!m_p[i], "R8", "final drain", longint'(m_p[i]), 0);
        chk(!dl_valid, "R8", "idle after drain", longint'(dl_valid), 0);
        check_table("R7");
        report();
        $finish;
    end
endmodule